// File: doc/BRIEF.md
# Haptic Driver Control Register Target

This block is the two-wire serial target that holds the control state of a haptic motor driver. A host reaches it over SCL/SDA at a fixed 7-bit address. The host writes one byte into one of six 8-bit registers, or reads one byte back. Both lines are brought into the system clock domain through a two-flop synchronizer. The block finds START, repeated START and STOP by comparing successive synchronized samples. It drives SDA only through a pull-low enable, so the line is never actively driven high.

A write transfer is START, address with R/W=0, ACK, register pointer, ACK, one data byte, ACK, STOP. A read transfer sets the pointer the same way, then sends a repeated START and the address with R/W=1. After the ACK, the block returns one byte MSB first, and the host ends with NACK and STOP. The register contents leave the block as decoded fields for the pulse sequencer, the timer prescaler and the regulator-level selector. An over-temperature input sets a sticky read-only flag that only the device reset clears. The system clock must run at least 8 times faster than SCL.

Top module: `haptic_i2c_regs`

## Requirements
- R1: While rst_ni is low, SDA is never pulled low. After reset the registers are 00h=01h, 01h=00h, 02h=0Ah, 03h=85h, 04h=00h and 05h=1Ah, and the field outputs follow from these values.
- R2: The block acknowledges an address byte only when its upper seven bits are 1100110 (MSB first, followed by R/W with write=0 and read=1). It acknowledges by pulling SDA low during the ninth SCL pulse. Any other address gets no ACK, and the rest of that transfer changes nothing.
- R3: A write transfer of address+W, pointer and one data byte gets an ACK after each byte and stores the data at the pointer.
- R4: A read transfer returns the byte at the current pointer MSB first after the repeated START and address+R. A START always restarts address reception.
- R5: Register 00h uses bit 0 as enable, bit 1 as trigger request, bit 2 as continuous-run request, bit 3 as over-temperature flag and bit 4 as auto-repeat. Bits 7:5 ignore writes and read as 0.
- R6: The over-temperature flag (00h bit 3) is set in the clock after ovt_i is high. It stays set until rst_ni goes low. Register writes can neither set nor clear it, including a write that falls in the same clock as ovt_i.
- R7: Field layout is as follows. Register 01h: bit 0 is the external timebase select, and bits 3:1 select the divide-by-2, by-4 and by-16 stages. Register 02h: bits 7:4 coast, bits 3:0 forward. Register 03h: bits 7:4 recovery, bits 3:0 reverse. Registers 04h and 05h: bits 4:0 give the pulse and continuous regulator codes. Bits outside these fields read as 0.
- R8: Pointers 06h to FFh are acknowledged. Writes to them change no register, and reads from them return 00h.
- R9: sda_oe_o changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Asynchronous active-low device reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| ovt_i | input | 1 | Over-temperature event |
| chip_en_o | output | 1 | Register 00h bit 0 |
| trig_req_o | output | 1 | Register 00h bit 1 |
| vib_req_o | output | 1 | Register 00h bit 2 |
| temp_flag_o | output | 1 | Sticky over-temperature flag |
| repeat_o | output | 1 | Register 00h bit 4 |
| ext_osc_o | output | 1 | Register 01h bit 0 |
| div_sel_o | output | 3 | Register 01h bits 3:1 |
| fwd_time_o | output | 4 | Register 02h bits 3:0 |
| coast_time_o | output | 4 | Register 02h bits 7:4 |
| rev_time_o | output | 4 | Register 03h bits 3:0 |
| recov_time_o | output | 4 | Register 03h bits 7:4 |
| ldo_pulse_o | output | 5 | Register 04h bits 4:0 |
| ldo_cont_o | output | 5 | Register 05h bits 4:0 |

## Verification
A host write to register 00h and an over-temperature event can land in the same system clock. In that case the flag must win against the written byte. The bench raises ovt_i for exactly one clock: the clock in which the last data bit's SCL rise passes the synchronizer and the byte is committed. The data byte written is 00h. The collision is judged by reading back 08h and by seeing the enable output go low while the flag output stays high. A second, plain write then confirms that the flag cannot be cleared by the host.

// File: rtl/hdrv_pkg.sv
package hdrv_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_REGS = 6;
  localparam int unsigned PTR_W    = 8;
  localparam int unsigned TEMP_BIT = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_ADDR, ST_PTR, ST_ACK_PTR,
    ST_WDATA, ST_ACK_WDATA, ST_RDATA, ST_RACK
  } bus_st_e;

  function automatic logic [REG_W-1:0] reg_default(input int unsigned idx);
    case (idx)
      0: return 8'h01;
      2: return 8'h0A;
      3: return 8'h85;
      5: return 8'h1A;
      default: return 8'h00;
    endcase
  endfunction

  // host-writable bits; flag bit of reg 0 is excluded
  function automatic logic [REG_W-1:0] reg_wmask(input int unsigned idx);
    case (idx)
      0: return 8'h17;
      1: return 8'h0F;
      2, 3: return 8'hFF;
      default: return 8'h1F;
    endcase
  endfunction
endpackage

// File: rtl/hdrv_line_sync.sv
module hdrv_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  logic scl_d, sda_d;
  assign scl_o   = scl_p[STAGES-1];
  assign sda_o   = sda_p[STAGES-1];
  assign scl_d   = scl_p[STAGES];
  assign sda_d   = sda_p[STAGES];
  assign start_o = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o  = scl_o & scl_d & ~sda_d & sda_o;
  assign rise_o  = scl_o & ~scl_d;
  assign fall_o  = ~scl_o & scl_d;
endmodule

// File: rtl/hdrv_i2c_fsm.sv
module hdrv_i2c_fsm
  import hdrv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1100110
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [REG_W-1:0] rd_data_i,
  output logic             sda_oe_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             wr_en_o,
  output logic [REG_W-1:0] wr_data_o
);
  bus_st_e          st_q;
  logic [2:0]       cnt_q;
  logic [REG_W-1:0] sh_q;
  logic             rw_q;
  logic [REG_W-1:0] byte_in;

  assign byte_in   = {sh_q[REG_W-2:0], sda_s_i};
  assign wr_data_o = byte_in;
  assign wr_en_o   = (st_q == ST_WDATA) && rise_i && (cnt_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      rw_q     <= 1'b0;
      ptr_o    <= '0;
      sda_oe_o <= 1'b0;
    end else if (start_i) begin
      st_q     <= ST_ADDR;
      cnt_q    <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_i) begin
      st_q     <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_PTR, ST_WDATA: if (rise_i) begin
          sh_q  <= byte_in;
          cnt_q <= cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            case (st_q)
              ST_ADDR: begin
                rw_q <= sda_s_i;
                st_q <= (sh_q[6:0] == DEV_ADDR) ? ST_ACK_ADDR : ST_IDLE;
              end
              ST_PTR: begin
                ptr_o <= byte_in;
                st_q  <= ST_ACK_PTR;
              end
              default: st_q <= ST_ACK_WDATA;
            endcase
          end
        end
        ST_ACK_ADDR, ST_ACK_PTR, ST_ACK_WDATA: if (fall_i) begin
          if (!sda_oe_o) begin
            sda_oe_o <= 1'b1;
          end else begin
            sda_oe_o <= 1'b0;
            cnt_q    <= '0;
            case (st_q)
              ST_ACK_ADDR: if (rw_q) begin
                st_q     <= ST_RDATA;
                sh_q     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[REG_W-1];
              end else begin
                st_q <= ST_PTR;
              end
              ST_ACK_PTR: st_q <= ST_WDATA;
              default:    st_q <= ST_IDLE;
            endcase
          end
        end
        ST_RDATA: if (fall_i) begin
          cnt_q <= cnt_q + 3'd1;
          sh_q  <= {sh_q[REG_W-2:0], 1'b0};
          if (cnt_q == 3'd7) begin
            sda_oe_o <= 1'b0;
            st_q     <= ST_RACK;
          end else begin
            sda_oe_o <= ~sh_q[REG_W-2];
          end
        end
        ST_RACK: if (rise_i) st_q <= ST_IDLE;
        default: ;
      endcase
    end
  end

  p_sda_move_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_o) || $fell(sda_oe_o)) |-> !scl_s_i);

  p_start_rearms_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st_q == ST_ADDR) && !sda_oe_o);

  p_foreign_addr_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADDR && rise_i && cnt_q == 3'd7 && !start_i && !stop_i
     && sh_q[6:0] != DEV_ADDR) |=> (st_q == ST_IDLE) && !sda_oe_o);
endmodule

// File: rtl/hdrv_regs.sv
module hdrv_regs
  import hdrv_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [PTR_W-1:0]               wr_addr_i,
  input  logic [REG_W-1:0]               wr_data_i,
  input  logic                           ovt_i,
  output logic [REG_W-1:0]               rd_data_o,
  output logic [NUM_REGS-1:0][REG_W-1:0] regs_o,
  output logic                           temp_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0][REG_W-1:0] regs_q;
  logic                           temp_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[i] <= reg_default(i);
      else if (wr_en_i && wr_addr_i == PTR_W'(i))
        regs_q[i] <= wr_data_i & reg_wmask(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) temp_q <= 1'b0;
    else         temp_q <= temp_q | ovt_i;
  end

  logic [IDX_W-1:0] idx;
  assign idx = wr_addr_i[IDX_W-1:0];

  always_comb begin
    rd_data_o = '0;
    if (wr_addr_i < PTR_W'(NUM_REGS)) begin
      rd_data_o = regs_q[idx];
      if (idx == '0) rd_data_o[TEMP_BIT] = temp_q;
    end
  end

  assign regs_o = regs_q;
  assign temp_o = temp_q;

  p_temp_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_q |=> temp_q);

  p_temp_catch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovt_i |=> temp_q);

  p_undef_write_inert_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i >= PTR_W'(NUM_REGS)) |=> $stable(regs_q));

  p_write_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 8'd2) |=> regs_q[2] == $past(wr_data_i));
endmodule

// File: rtl/haptic_i2c_regs.sv
module haptic_i2c_regs
  import hdrv_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'b1100110,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       ovt_i,
  output logic       chip_en_o,
  output logic       trig_req_o,
  output logic       vib_req_o,
  output logic       temp_flag_o,
  output logic       repeat_o,
  output logic       ext_osc_o,
  output logic [2:0] div_sel_o,
  output logic [3:0] fwd_time_o,
  output logic [3:0] coast_time_o,
  output logic [3:0] rev_time_o,
  output logic [3:0] recov_time_o,
  output logic [4:0] ldo_pulse_o,
  output logic [4:0] ldo_cont_o
);
  logic scl_s, sda_s, start, stop, rise, fall;
  logic wr_en;
  logic [PTR_W-1:0] ptr;
  logic [REG_W-1:0] wr_data, rd_data;
  logic [NUM_REGS-1:0][REG_W-1:0] regs;

  hdrv_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .start_o(start), .stop_o(stop),
    .rise_o(rise), .fall_o(fall)
  );

  hdrv_i2c_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .start_i(start), .stop_i(stop), .rise_i(rise), .fall_i(fall),
    .rd_data_i(rd_data), .sda_oe_o, .ptr_o(ptr),
    .wr_en_o(wr_en), .wr_data_o(wr_data)
  );

  hdrv_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(ptr), .wr_data_i(wr_data),
    .ovt_i, .rd_data_o(rd_data), .regs_o(regs), .temp_o(temp_flag_o)
  );

  assign chip_en_o    = regs[0][0];
  assign trig_req_o   = regs[0][1];
  assign vib_req_o    = regs[0][2];
  assign repeat_o     = regs[0][4];
  assign ext_osc_o    = regs[1][0];
  assign div_sel_o    = regs[1][3:1];
  assign fwd_time_o   = regs[2][3:0];
  assign coast_time_o = regs[2][7:4];
  assign rev_time_o   = regs[3][3:0];
  assign recov_time_o = regs[3][7:4];
  assign ldo_pulse_o  = regs[4][4:0];
  assign ldo_cont_o   = regs[5][4:0];

  logic unused_bits;
  assign unused_bits = ^{regs[0][7:5], regs[0][3], regs[1][7:4],
                         regs[4][7:5], regs[5][7:5]};
endmodule

// File: tb/haptic_i2c_regs_tb_top.sv
module haptic_i2c_regs_tb_top;
  localparam logic [6:0] DEV = 7'b1100110;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, ovt = 1'b0;
  logic sda_oe, chip_en, trig_req, vib_req, temp_flag, rpt, ext_osc;
  logic [2:0] div_sel;
  logic [3:0] fwd, coast, rev, recov;
  logic [4:0] ldo_p, ldo_c;
  wire sda_line = sda_m & ~sda_oe;

  haptic_i2c_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .ovt_i(ovt), .chip_en_o(chip_en), .trig_req_o(trig_req),
    .vib_req_o(vib_req), .temp_flag_o(temp_flag), .repeat_o(rpt),
    .ext_osc_o(ext_osc), .div_sel_o(div_sel), .fwd_time_o(fwd),
    .coast_time_o(coast), .rev_time_o(rev), .recov_time_o(recov),
    .ldo_pulse_o(ldo_p), .ldo_cont_o(ldo_c)
  );

  typedef struct { string tag; logic [7:0] val; } item_t;
  item_t exp_q[$], act_q[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares read-back bytes as they arrive
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0) begin
      item_t a, e;
      a = act_q.pop_front();
      if (exp_q.size() == 0) check({a.tag, " no expected item"}, a.val, 8'hxx);
      else begin
        e = exp_q.pop_front();
        check(e.tag, a.val, e.val);
      end
    end
  end

  task automatic q_wait(); repeat (8) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; q_wait();
    scl_m = 1'b1; q_wait();
    sda_m = 1'b0; q_wait();
    scl_m = 1'b0; q_wait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q_wait();
    scl_m = 1'b1; q_wait();
    sda_m = 1'b1; q_wait();
  endtask

  task automatic bus_bit(input logic b, input bit pulse, output logic seen);
    sda_m = b; q_wait();
    scl_m = 1'b1;
    if (pulse) begin
      // ovt high only in the clock that commits the byte
      repeat (2) @(negedge clk);
      ovt = 1'b1;
      @(negedge clk);
      ovt = 1'b0;
      repeat (5) @(negedge clk);
    end else q_wait();
    seen = sda_line;
    scl_m = 1'b0; q_wait();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit pulse_last, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], pulse_last && i == 0, s);
    bus_bit(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, 1'b0, s);
      b[i] = s;
    end
    bus_bit(1'b1, 1'b0, s); // host NACK
  endtask

  task automatic wr_reg(input logic [6:0] dev, input logic [7:0] ptr,
                        input logic [7:0] data, input bit pulse);
    logic ack;
    bus_start();
    send_byte({dev, 1'b0}, 1'b0, ack);
    if (dev != DEV) begin
      check("R2 foreign address not acknowledged", ack, 1'b0);
      send_byte(ptr, 1'b0, ack);
      check("R2 no ACK after foreign address", ack, 1'b0);
      send_byte(data, 1'b0, ack);
    end else begin
      check("R2 address write ACK", ack, 1'b1);
      send_byte(ptr, 1'b0, ack);
      check(ptr > 8'd5 ? "R8 undefined pointer ACK" : "R3 pointer ACK", ack, 1'b1);
      send_byte(data, pulse, ack);
      check("R3 data ACK", ack, 1'b1);
    end
    bus_stop();
  endtask

  task automatic rd_reg(input logic [7:0] ptr, input logic [7:0] exp, input string tag);
    logic ack;
    logic [7:0] got;
    bus_start();
    send_byte({DEV, 1'b0}, 1'b0, ack);
    check("R2 address ACK before read", ack, 1'b1);
    send_byte(ptr, 1'b0, ack);
    check("R4 read pointer ACK", ack, 1'b1);
    bus_start();
    send_byte({DEV, 1'b1}, 1'b0, ack);
    check("R4 address+R ACK", ack, 1'b1);
    exp_q.push_back('{tag, exp});
    recv_byte(got);
    act_q.push_back('{tag, got});
    bus_stop();
  endtask

  task automatic check_defaults(input string tag);
    check({tag, " R1 enable"}, chip_en, 1'b1);
    check({tag, " R1 requests"}, {trig_req, vib_req, rpt}, 3'b000);
    check({tag, " R1 timebase"}, {ext_osc, div_sel}, 4'h0);
    check({tag, " R1 timers"}, {coast, fwd, recov, rev}, 16'h0A85);
    check({tag, " R1 regulator"}, {ldo_p, ldo_c}, {5'h00, 5'h1A});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 SDA released in reset", sda_oe, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_defaults("post-reset");
    check("R6 flag clear after reset", temp_flag, 1'b0);
    rd_reg(8'h00, 8'h01, "R1 reg00 default");
    rd_reg(8'h01, 8'h00, "R1 reg01 default");
    rd_reg(8'h02, 8'h0A, "R1 reg02 default");
    rd_reg(8'h03, 8'h85, "R1 reg03 default");
    rd_reg(8'h04, 8'h00, "R1 reg04 default");
    rd_reg(8'h05, 8'h1A, "R1 reg05 default");

    wr_reg(7'b1100111, 8'h02, 8'h55, 1'b0);
    check("R2 foreign write leaves timers", {coast, fwd}, 8'h0A);

    wr_reg(DEV, 8'h02, 8'h3C, 1'b0);
    check("R3 R7 coast field", coast, 4'h3);
    check("R3 R7 forward field", fwd, 4'hC);
    wr_reg(DEV, 8'h03, 8'hF1, 1'b0);
    check("R7 recovery/reverse fields", {recov, rev}, 8'hF1);
    rd_reg(8'h03, 8'hF1, "R4 reg03 readback");

    wr_reg(DEV, 8'h01, 8'hFF, 1'b0);
    check("R7 timebase fields", {ext_osc, div_sel}, 4'hF);
    rd_reg(8'h01, 8'h0F, "R7 reg01 upper bits zero");
    wr_reg(DEV, 8'h04, 8'hFF, 1'b0);
    wr_reg(DEV, 8'h05, 8'hE5, 1'b0);
    check("R7 regulator codes", {ldo_p, ldo_c}, {5'h1F, 5'h05});
    rd_reg(8'h05, 8'h05, "R7 reg05 upper bits zero");

    wr_reg(DEV, 8'h00, 8'hFF, 1'b0);
    check("R5 control bits", {rpt, vib_req, trig_req, chip_en}, 4'hF);
    check("R6 write cannot set flag", temp_flag, 1'b0);
    rd_reg(8'h00, 8'h17, "R5 R6 reg00 readback");

    wr_reg(DEV, 8'h07, 8'hAA, 1'b0);
    rd_reg(8'h07, 8'h00, "R8 undefined read zero");
    rd_reg(8'h00, 8'h17, "R8 reg00 untouched");
    check("R8 timers untouched", {coast, fwd, recov, rev}, 16'h3CF1);

    wr_reg(DEV, 8'h00, 8'h00, 1'b1);
    check("R6 flag wins collision", temp_flag, 1'b1);
    check("R6 write applied in collision", chip_en, 1'b0);
    rd_reg(8'h00, 8'h08, "R6 reg00 after collision");
    wr_reg(DEV, 8'h00, 8'h01, 1'b0);
    rd_reg(8'h00, 8'h09, "R6 flag not cleared by write");

    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 SDA released during reset", sda_oe, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 reset clears flag", temp_flag, 1'b0);
    check_defaults("second reset");
    rd_reg(8'h00, 8'h01, "R1 reg00 after reset");

    repeat (4) @(negedge clk);
    check("R4 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule